// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Sequencer

This block is a clocked sequencer for a conventional asynchronous DRAM whose row and column addresses share one set of pins. The host hands it one request at a time: a write flag, a timing-variant flag, a full address and write data. The block drives the four active-low strobes (row strobe, column strobe, write enable, output enable), the shared address pins and a bidirectional data bus. Read data comes back on `rd_data`, marked by a one-cycle `rd_valid` pulse.

Every analog timing figure is given in nanoseconds and turned into a whole number of clock cycles at elaboration. The conversion rounds up and never gives less than one cycle. A down-counter holds the sequencer in each timed state for that many cycles. Two more counters run from the row-strobe falling edge: one for the row access time and one for the minimum spacing between row cycles. A third counter runs from the start of the column phase, for the column access time or the write pulse width.

The `req_late` flag picks the variant for the request. For a read it chooses whether output enable falls before or after the column strobe. For a write it chooses whether write enable falls before or after the column strobe. The host holds `req_valid` and its fields until it sees `req_ready` high at a clock edge.

Top module: `adram_seq`

## Requirements
- R1: While reset is held, and after it, the four strobes read 1, the data pins are released (high impedance), `req_ready` is 1 and `rd_valid` is 0.
- R2: At the row-strobe falling edge the address pins carry the row field, which is `req_addr[ROW_W+COL_W-1:COL_W]`. At the column-strobe falling edge they carry the column field, which is `req_addr[COL_W-1:0]`.
- R3: The address pins stay unchanged for at least the row-setup cycle count before the row strobe falls. They stay unchanged for at least the column-setup cycle count before the column strobe falls.
- R4: A read with `req_late`=0 pulls output enable low while the column strobe is still high.
- R5: A read with `req_late`=1 pulls output enable low only after the column strobe is already low.
- R6: A write pulls write enable low before the column strobe falls when `req_late`=0, and after it when `req_late`=1. Output enable stays high throughout a write.
- R7: The block drives the data pins, carrying the request's write data, exactly while write enable is low. Write enable and output enable are never low together.
- R8: Read data is captured no sooner than the row-access count after the row strobe falls. It is also captured no sooner than the column-access count after the later of the column-strobe fall and the output-enable fall. `rd_valid` lasts one cycle and carries the addressed word.
- R9: A cycle ends with all strobes returning high on the same edge. `req_ready` is high only with the strobes high, and no sooner than the row-cycle count after the last row-strobe fall. Successive row-strobe falls are at least that far apart.
- R10: The column strobe is low only while the row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_late | input | 1 | 1 = late enable variant, 0 = early |
| req_addr | input | ROW_W+COL_W | Full word address, row field on top |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request is taken at this edge if valid |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Captured read word |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_dq | inout | DATA_W | Bidirectional data pins |

## Verification
Two things can land on the same edge. The column-access wait ends, which lets the read word be captured, and the strobes are released, which is when the memory stops driving the bus. Reads that follow a write to the same address, in both early and late variants, put data capture on that release edge. Checking `rd_data` against a bench reference model shows whether the word was taken before the bus went undriven. A second case is requests held while the row-cycle counter is still running. Here readiness and the end of the previous cycle come close together, and the bench judges this by the row-strobe spacing and the cycle count of `req_ready`.

// File: rtl/adram_pkg.sv
package adram_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ROW_SU,
      S_ROW_HOLD,
      S_COL_SU,
      S_COL_HOLD,
      S_ACCESS
   } seq_state_t;

   // nanoseconds to clock cycles, rounded up, never below one
   function automatic int unsigned ns2cyc(input int unsigned t_ns, input int unsigned clk_ns);
      int unsigned c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adram_dn_ctr.sv
module adram_dn_ctr #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] value,
   output logic          done
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= value;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/adram_addr_mux.sv
module adram_addr_mux #(
   parameter int ROW_W = 9,
   parameter int COL_W = 9,
   parameter int AW    = 9
) (
   input  logic [ROW_W-1:0] row,
   input  logic [COL_W-1:0] col,
   input  logic             sel_col,
   output logic [AW-1:0]    pins
);
   logic [AW-1:0] row_x;
   logic [AW-1:0] col_x;

   generate
      if (ROW_W == AW) begin : g_row_full
         assign row_x = row;
      end else begin : g_row_pad
         assign row_x = {{(AW-ROW_W){1'b0}}, row};
      end
      if (COL_W == AW) begin : g_col_full
         assign col_x = col;
      end else begin : g_col_pad
         assign col_x = {{(AW-COL_W){1'b0}}, col};
      end
   endgenerate

   assign pins = sel_col ? col_x : row_x;
endmodule

// File: rtl/adram_seq.sv
module adram_seq
   import adram_pkg::*;
#(
   parameter int ROW_W      = 9,
   parameter int COL_W      = 9,
   parameter int DATA_W     = 8,
   parameter int CLK_NS     = 10,
   parameter int T_RSU_NS   = 10,
   parameter int T_RHOLD_NS = 10,
   parameter int T_CSU_NS   = 10,
   parameter int T_CHOLD_NS = 10,
   parameter int T_RAC_NS   = 60,
   parameter int T_CAC_NS   = 15,
   parameter int T_WP_NS    = 15,
   parameter int T_RC_NS    = 110
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic                   req_late,
   input  logic [ROW_W+COL_W-1:0] req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   output logic                   req_ready,
   output logic                   rd_valid,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   dram_ras_n,
   output logic                   dram_cas_n,
   output logic                   dram_we_n,
   output logic                   dram_oe_n,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
   inout  wire  [DATA_W-1:0]      dram_dq
);
   localparam int AW       = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int NR_RSU   = ns2cyc(T_RSU_NS, CLK_NS);
   localparam int NR_RHOLD = ns2cyc(T_RHOLD_NS, CLK_NS);
   localparam int NR_CSU   = ns2cyc(T_CSU_NS, CLK_NS);
   localparam int NR_CHOLD = ns2cyc(T_CHOLD_NS, CLK_NS);
   localparam int NR_RAC   = ns2cyc(T_RAC_NS, CLK_NS);
   localparam int NR_CAC   = ns2cyc(T_CAC_NS, CLK_NS);
   localparam int NR_WP    = ns2cyc(T_WP_NS, CLK_NS);
   localparam int NR_RC    = ns2cyc(T_RC_NS, CLK_NS);
   localparam int NR_MAX   = umax(umax(umax(NR_RSU, NR_RHOLD), umax(NR_CSU, NR_CHOLD)),
                                  umax(umax(NR_RAC, NR_CAC), umax(NR_WP, NR_RC)));
   localparam int CW       = $clog2(NR_MAX + 1);

   generate
      if (ROW_W < 1 || COL_W < 1) begin : g_bad_addr
         $error("adram_seq: address fields need at least one bit");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("adram_seq: DATA_W must be positive");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("adram_seq: CLK_NS must be positive");
      end
   endgenerate

   seq_state_t         st_q;
   logic [CW-1:0]      wait_q;
   logic               wait_last;
   logic               write_q, late_q;
   logic [ROW_W-1:0]   row_q;
   logic [COL_W-1:0]   col_q;
   logic [DATA_W-1:0]  wdata_q;
   logic               sel_col_q, dq_en_q;
   logic               ras_n_q, cas_n_q, we_n_q, oe_n_q;
   logic               rd_valid_q;
   logic [DATA_W-1:0]  rd_data_q;
   logic               ld_row_timers, ld_col, accept, acc_done;
   logic               rac_done, rc_done, col_done;
   logic [CW-1:0]      col_len;

   assign wait_last = (wait_q <= CW'(1));
   assign req_ready = (st_q == S_IDLE) && rc_done;
   assign accept    = req_ready && req_valid;
   assign col_len   = write_q ? CW'(NR_WP) : CW'(NR_CAC);
   assign acc_done  = col_done && (write_q || rac_done);

   always_comb begin
      ld_row_timers = 1'b0;
      ld_col        = 1'b0;
      case (st_q)
         S_ROW_SU:   ld_row_timers = wait_last;
         S_COL_SU:   ld_col        = wait_last && !late_q;
         S_COL_HOLD: ld_col        = wait_last && late_q;
         default:    ;
      endcase
   end

   adram_dn_ctr #(.CW(CW)) u_rc_ctr (
      .clk(clk), .rst_n(rst_n), .load(ld_row_timers), .value(CW'(NR_RC)), .done(rc_done));
   adram_dn_ctr #(.CW(CW)) u_rac_ctr (
      .clk(clk), .rst_n(rst_n), .load(ld_row_timers), .value(CW'(NR_RAC)), .done(rac_done));
   adram_dn_ctr #(.CW(CW)) u_col_ctr (
      .clk(clk), .rst_n(rst_n), .load(ld_col), .value(col_len), .done(col_done));

   adram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .AW(AW)) u_addr_mux (
      .row(row_q), .col(col_q), .sel_col(sel_col_q), .pins(dram_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         wait_q     <= '0;
         write_q    <= 1'b0;
         late_q     <= 1'b0;
         row_q      <= '0;
         col_q      <= '0;
         wdata_q    <= '0;
         sel_col_q  <= 1'b0;
         dq_en_q    <= 1'b0;
         ras_n_q    <= 1'b1;
         cas_n_q    <= 1'b1;
         we_n_q     <= 1'b1;
         oe_n_q     <= 1'b1;
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= 1'b0;
         if (st_q != S_IDLE && st_q != S_ACCESS && !wait_last) wait_q <= wait_q - 1'b1;
         case (st_q)
            S_IDLE: if (accept) begin
               write_q   <= req_write;
               late_q    <= req_late;
               row_q     <= req_addr[ROW_W+COL_W-1:COL_W];
               col_q     <= req_addr[COL_W-1:0];
               wdata_q   <= req_wdata;
               sel_col_q <= 1'b0;
               wait_q    <= CW'(NR_RSU);
               st_q      <= S_ROW_SU;
            end
            S_ROW_SU: if (wait_last) begin
               ras_n_q <= 1'b0;
               wait_q  <= CW'(NR_RHOLD);
               st_q    <= S_ROW_HOLD;
            end
            S_ROW_HOLD: if (wait_last) begin
               sel_col_q <= 1'b1;
               if (!late_q) begin
                  if (write_q) begin
                     we_n_q  <= 1'b0;
                     dq_en_q <= 1'b1;
                  end else begin
                     oe_n_q  <= 1'b0;
                  end
               end
               wait_q <= CW'(NR_CSU);
               st_q   <= S_COL_SU;
            end
            S_COL_SU: if (wait_last) begin
               cas_n_q <= 1'b0;
               wait_q  <= CW'(NR_CHOLD);
               st_q    <= S_COL_HOLD;
            end
            S_COL_HOLD: if (wait_last) begin
               if (late_q) begin
                  if (write_q) begin
                     we_n_q  <= 1'b0;
                     dq_en_q <= 1'b1;
                  end else begin
                     oe_n_q  <= 1'b0;
                  end
               end
               st_q <= S_ACCESS;
            end
            S_ACCESS: if (acc_done) begin
               ras_n_q <= 1'b1;
               cas_n_q <= 1'b1;
               we_n_q  <= 1'b1;
               oe_n_q  <= 1'b1;
               dq_en_q <= 1'b0;
               if (!write_q) begin
                  rd_valid_q <= 1'b1;
                  rd_data_q  <= dram_dq;
               end
               st_q <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign dram_dq    = dq_en_q ? wdata_q : {DATA_W{1'bz}};
   assign dram_ras_n = ras_n_q;
   assign dram_cas_n = cas_n_q;
   assign dram_we_n  = we_n_q;
   assign dram_oe_n  = oe_n_q;
   assign rd_valid   = rd_valid_q;
   assign rd_data    = rd_data_q;
endmodule

// File: rtl/adram_seq_chk.sv
module adram_seq_chk #(
   parameter int AW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ras_n,
   input logic          cas_n,
   input logic          we_n,
   input logic          oe_n,
   input logic [AW-1:0] addr,
   input logic          ready,
   input logic          rd_valid,
   input logic          late_q,
   input logic          write_q
);
   assert_cas_in_ras_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);
   assert_we_oe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !oe_n));
   assert_row_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> $stable(addr));
   assert_col_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> $stable(addr));
   assert_early_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(oe_n) && !late_q) |-> cas_n);
   assert_late_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(oe_n) && late_q) |-> !cas_n);
   assert_write_no_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && write_q) |-> oe_n);
   assert_rd_after_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> ($past(oe_n) == 1'b0));
   assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (ras_n && cas_n && we_n && oe_n));
endmodule

bind adram_seq adram_seq_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
   .we_n(dram_we_n), .oe_n(dram_oe_n), .addr(dram_addr), .ready(req_ready),
   .rd_valid(rd_valid), .late_q(late_q), .write_q(write_q));

// File: tb/adram_seq_tb_top.sv
module adram_seq_tb_top;
   localparam int RW = 9, CWD = 9, DW = 8, AWB = 18;

   function automatic int cyc(input int t);
      int c;
      c = (t + 9) / 10;
      return (c < 1) ? 1 : c;
   endfunction
   localparam int E_RSU = 1, E_CSU = 1;
   int e_rac, e_cac, e_rc;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_write = 0, req_late = 0;
   logic [AWB-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rd_valid;
   logic [DW-1:0] rd_data;
   logic ras_n, cas_n, we_n, oe_n;
   logic [RW-1:0] dram_addr;
   wire  [DW-1:0] dram_dq;

   logic [DW-1:0] mdl_q = '0;
   assign dram_dq = (!oe_n && we_n) ? mdl_q : {DW{1'bz}};

   adram_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_late(req_late), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
      .dram_addr(dram_addr), .dram_dq(dram_dq));

   always #5 clk = ~clk;

   int checks = 0, failures = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input string detail);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: %s", tag, detail);
      end
   endtask

   function automatic logic [DW-1:0] init_val(input logic [AWB-1:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   logic [DW-1:0] mem  [int];
   logic [DW-1:0] refm [int];

   // current transaction as seen by the host
   bit cur_wr, cur_late;
   logic [AWB-1:0] cur_a;
   logic [DW-1:0] cur_d;
   int done_cnt = 0;

   // pin monitor state
   logic p_ras = 1, p_cas = 1, p_we = 1, p_oe = 1;
   logic [RW-1:0] p_addr = '0;
   int stable = 0, ras_age = 1000, col_age = 0;
   bit seen_ras = 0;
   logic [RW-1:0] lat_row = '0, lat_col = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         stable = (dram_addr == p_addr) ? stable + 1 : 0;
         ras_age++;
         col_age++;
         if (p_ras && !ras_n) begin
            chk(dram_addr == cur_a[AWB-1:CWD], "R2",
                $sformatf("row act=%h exp=%h", dram_addr, cur_a[AWB-1:CWD]));
            chk(stable >= E_RSU, "R3", $sformatf("row setup act=%0d exp>=%0d", stable, E_RSU));
            if (seen_ras)
               chk(ras_age >= e_rc, "R9", $sformatf("ras spacing act=%0d exp>=%0d", ras_age, e_rc));
            seen_ras = 1;
            ras_age  = 0;
            lat_row  = dram_addr;
         end
         if (p_cas && !cas_n) begin
            chk(dram_addr == cur_a[CWD-1:0], "R2",
                $sformatf("col act=%h exp=%h", dram_addr, cur_a[CWD-1:0]));
            chk(stable >= E_CSU, "R3", $sformatf("col setup act=%0d exp>=%0d", stable, E_CSU));
            lat_col = dram_addr;
            if (!cur_wr && !cur_late)
               chk(!oe_n, "R4", $sformatf("oe at cas fall act=%b exp=0", oe_n));
            if (!cur_wr && cur_late)
               chk(oe_n, "R5", $sformatf("oe at cas fall act=%b exp=1", oe_n));
            if (cur_wr)
               chk(we_n == cur_late, "R6", $sformatf("we at cas fall act=%b exp=%b", we_n, cur_late));
            col_age = 0;
         end
         if (p_oe && !oe_n && !cas_n) col_age = 0;
         if (!cas_n && !we_n && (p_cas || p_we)) begin
            chk(dram_dq === cur_d, "R7", $sformatf("write dq act=%h exp=%h", dram_dq, cur_d));
            chk(oe_n, "R6", $sformatf("oe in write act=%b exp=1", oe_n));
            mem[int'({lat_row, lat_col})] = dram_dq;
         end
         if (we_n && oe_n)
            chk(dram_dq === {DW{1'bz}}, "R7", $sformatf("released dq act=%h exp=z", dram_dq));
         if (!we_n)
            chk(dram_dq === cur_d, "R7", $sformatf("driven dq act=%h exp=%h", dram_dq, cur_d));
         if (!cas_n)
            chk(!ras_n, "R10", $sformatf("cas low with ras act=%b exp=0", ras_n));
         if (rd_valid) begin
            logic [DW-1:0] e;
            e = refm.exists(int'(cur_a)) ? refm[int'(cur_a)] : init_val(cur_a);
            chk(rd_data == e, "R8", $sformatf("rd_data act=%h exp=%h", rd_data, e));
            chk(ras_age >= e_rac, "R8", $sformatf("rac act=%0d exp>=%0d", ras_age, e_rac));
            chk(col_age >= e_cac, "R8", $sformatf("cac act=%0d exp>=%0d", col_age, e_cac));
            chk(ras_n && cas_n && oe_n && we_n, "R9",
                $sformatf("strobes at end act=%b%b%b%b exp=1111", ras_n, cas_n, we_n, oe_n));
         end
         if (p_rd_valid_q && rd_valid)
            chk(0, "R8", "rd_valid act=2 cycles exp=1");
         if (!p_ras && ras_n) done_cnt++;
         if (req_ready) begin
            chk(ras_n && cas_n, "R9", $sformatf("ready with strobes act=%b%b exp=11", ras_n, cas_n));
            chk(ras_age >= e_rc, "R9", $sformatf("ready age act=%0d exp>=%0d", ras_age, e_rc));
         end
         mdl_q = mem.exists(int'({lat_row, lat_col})) ? mem[int'({lat_row, lat_col})]
                                                     : init_val({lat_row, lat_col});
         p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_oe = oe_n; p_addr = dram_addr;
         p_rd_valid_q = rd_valid;
      end
   end
   logic p_rd_valid_q = 0;

   task automatic txn(input bit wr, input bit late, input logic [AWB-1:0] a, input logic [DW-1:0] d);
      int start;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_late = late; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      cur_wr = wr; cur_late = late; cur_a = a; cur_d = d;
      if (wr) refm[int'(a)] = d;
      start = done_cnt;
      @(negedge clk);
      req_valid = 0;
      req_write = $urandom_range(0, 1);
      req_addr  = AWB'($urandom);
      while (done_cnt == start) @(negedge clk);
   endtask

   logic [AWB-1:0] pool [8];

   initial begin
      e_rac = cyc(60); e_cac = cyc(15); e_rc = cyc(110);
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ras_n && cas_n && we_n && oe_n, "R1", $sformatf("strobes in reset act=%b%b%b%b exp=1111", ras_n, cas_n, we_n, oe_n));
      chk(dram_dq === {DW{1'bz}}, "R1", $sformatf("dq in reset act=%h exp=z", dram_dq));
      chk(!rd_valid, "R1", $sformatf("rd_valid act=%b exp=0", rd_valid));
      rst_n = 1;
      @(negedge clk);
      chk(req_ready, "R1", $sformatf("ready after reset act=%b exp=1", req_ready));
      // directed corners: all modes at extreme addresses
      txn(1, 0, '1, 8'hA5);
      txn(0, 0, '1, 8'h00);
      txn(0, 1, '1, 8'h00);
      txn(1, 1, '0, 8'h3C);
      txn(0, 1, '0, 8'h00);
      txn(0, 0, '0, 8'h00);
      txn(0, 0, 18'h12345, 8'h00);
      txn(1, 0, 18'h201FF, 8'hFF);
      txn(0, 1, 18'h201FF, 8'h00);
      for (int i = 0; i < 8; i++) pool[i] = AWB'($urandom);
      for (int i = 0; i < 80; i++)
         txn($urandom_range(0, 1), $urandom_range(0, 1), pool[$urandom_range(0, 7)], DW'($urandom));
      repeat (4) @(negedge clk);
      chk(ras_n && cas_n && we_n && oe_n, "R9", "strobes idle at end act!=1111 exp=1111");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog: act=hung exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule